// File: doc/BRIEF.md
# Early-Restart Line Refill Controller

This controller fills one cache line of four 32-bit words after a read miss. The cache presents the line address and the offset of the word the processor asked for. The controller then issues a single block read to main memory and accepts the returned words one beat at a time. Each beat is written into the line storage in the cycle it arrives. The processor stall is released as soon as the requested word is in the line. The remaining beats keep arriving and are written while the processor runs again.

A mode input selects how the memory orders the beats. In sequential order, word 0 comes first and word 3 comes last. In wrap order, the requested word comes first and the offset then counts upward modulo four. While the background fill runs, the controller also judges processor accesses. An access to the line being filled, at a word already written, is allowed through. Any other access is held until the refill ends. The line is marked valid only after its fourth word has been written. A miss presented during a refill is ignored.

The state machine has five states:

| State | Meaning |
|-------|---------|
| RF_IDLE | Waiting for a miss |
| RF_ISSUE | Sends the block read for one cycle |
| RF_WAIT_REQ | Stalled, waiting for the requested word |
| RF_BACKFILL | Processor running, remaining words arriving |
| RF_COMMIT | Marks the line valid for one cycle |

The transitions are:

| Name | From | To | Condition |
|------|------|----|-----------|
| T_accept | RF_IDLE | RF_ISSUE | miss presented |
| T_sent | RF_ISSUE | RF_WAIT_REQ | always |
| T_restart | RF_WAIT_REQ | RF_BACKFILL | requested word arrives and is not the last beat |
| T_direct | RF_WAIT_REQ | RF_COMMIT | requested word arrives as the last beat |
| T_filled | RF_BACKFILL | RF_COMMIT | last beat arrives |
| T_retire | RF_COMMIT | RF_IDLE | always |

Top module: `line_refill_ctrl`

## Requirements
- R1: A miss seen in RF_IDLE produces exactly one `mem_req` cycle on the next cycle. That cycle carries the missed line on `mem_line` and the first offset on `mem_first`: 0 in sequential mode, the requested offset in wrap mode (`wrap_mode`=1).
- R2: In sequential mode the line is written at offsets 0, 1, 2, 3 in that order.
- R3: In wrap mode the line is written at offsets r, r+1, r+2, r+3 modulo 4, where r is the requested offset.
- R4: Each accepted beat is written in the cycle it arrives. `line_widx` is its offset, `line_wdata` is the beat data and `line_wline` is the missed line. Exactly four writes happen per refill.
- R5: `stall` is high from the `mem_req` cycle up to and including the cycle the requested word is written, and low in the cycle after. With memory that sends the address in 1 cycle and then takes 10 access cycles plus 1 transfer cycle per word, `stall` is high for 12 + 11·p cycles, where p is the requested word's beat position.
- R6: `line_valid_set` pulses exactly once per refill, in the cycle after the fourth write.
- R7: `busy` is high from the `mem_req` cycle through the `line_valid_set` cycle and low in the next cycle. Under the memory timing in R5 this is 46 cycles.
- R8: A miss presented while `busy` is high issues no block read and does not change the line being filled.
- R9: `acc_hold` is high exactly when `busy`, `acc_valid` and one of two conditions hold: `acc_line` differs from the line being filled, or the word at `acc_word` has not been written in an earlier cycle of this refill.
- R10: After reset, `busy`, `stall`, `mem_req`, `line_we` and `line_valid_set` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss presented |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | OFF_W | Requested word offset |
| wrap_mode | input | 1 | 1 selects requested-word-first order |
| mem_req | output | 1 | One-cycle block read request |
| mem_line | output | LINE_AW | Line address of the block read |
| mem_first | output | OFF_W | Offset of the first beat to return |
| mem_beat_valid | input | 1 | Returned word valid |
| mem_beat_data | input | WORD_W | Returned word |
| line_we | output | 1 | Line storage write strobe |
| line_wline | output | LINE_AW | Line being written |
| line_widx | output | OFF_W | Word offset written |
| line_wdata | output | WORD_W | Word written |
| line_valid_set | output | 1 | Set the line valid bit |
| stall | output | 1 | Processor stall |
| busy | output | 1 | Refill in progress |
| acc_valid | input | 1 | Processor access during refill |
| acc_line | input | LINE_AW | Line address of the access |
| acc_word | input | OFF_W | Word offset of the access |
| acc_hold | output | 1 | Access must wait |

## Verification
The assertions assume that memory returns beats only after a block read. It returns exactly four of them, in the order set by `mem_first` modulo the line length, and no sooner than the cycle after `mem_req`. The bench meets this with a memory model that starts only on a sampled `mem_req`. The model counts ten access cycles plus one transfer cycle per beat and stops after the fourth beat. The bench drives processor accesses only as a pattern against the line being filled or a different line, so every input stays within the stated contract.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
    typedef enum logic [2:0] {
        RF_IDLE,
        RF_ISSUE,
        RF_WAIT_REQ,
        RF_BACKFILL,
        RF_COMMIT
    } rf_state_t;
endpackage

// File: rtl/rfl_order.sv
// Maps the beat count onto a word offset, for sequential or wrapped order.
module rfl_order #(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] req_word,
    input  logic             wrap,
    input  logic [OFF_W-1:0] beat_cnt,
    output logic [OFF_W-1:0] first,
    output logic [OFF_W-1:0] widx
);
    always_comb begin
        first = wrap ? req_word : '0;
        widx  = first + beat_cnt;   // wraps naturally at the line length
    end
endmodule

// File: rtl/rfl_track.sv
// Holds the captured miss, the beat counter and the per-word written mask.
module rfl_track #(
    parameter int LINE_WORDS = 4,
    parameter int LINE_AW    = 12,
    parameter int OFF_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LINE_AW-1:0]    start_line,
    input  logic [OFF_W-1:0]      start_word,
    input  logic                  start_wrap,
    input  logic                  beat,
    output logic [LINE_AW-1:0]    cur_line,
    output logic [OFF_W-1:0]      first,
    output logic [OFF_W-1:0]      widx,
    output logic [LINE_WORDS-1:0] written,
    output logic                  req_hit,
    output logic                  last_beat
);
    localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(LINE_WORDS - 1);

    logic [LINE_AW-1:0] line_q;
    logic [OFF_W-1:0]   req_q;
    logic               wrap_q;
    logic [OFF_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            req_q  <= '0;
            wrap_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            line_q <= start_line;
            req_q  <= start_word;
            wrap_q <= start_wrap;
            cnt_q  <= '0;
        end else if (beat) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    rfl_order #(.OFF_W(OFF_W)) u_order (
        .req_word (req_q),
        .wrap     (wrap_q),
        .beat_cnt (cnt_q),
        .first    (first),
        .widx     (widx)
    );

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n || start)
                written[i] <= 1'b0;
            else if (beat && widx == OFF_W'(i))
                written[i] <= 1'b1;
        end
    end

    assign cur_line  = line_q;
    assign req_hit   = beat && (widx == req_q);
    assign last_beat = beat && (cnt_q == LAST_CNT);
endmodule

// File: rtl/rfl_guard.sv
// Decides whether a processor access during a refill must wait.
module rfl_guard #(
    parameter int LINE_WORDS = 4,
    parameter int LINE_AW    = 12,
    parameter int OFF_W      = 2
) (
    input  logic                  busy,
    input  logic                  acc_valid,
    input  logic [LINE_AW-1:0]    acc_line,
    input  logic [OFF_W-1:0]      acc_word,
    input  logic [LINE_AW-1:0]    cur_line,
    input  logic [LINE_WORDS-1:0] written,
    output logic                  hold
);
    logic other_line;
    logic word_ready;

    always_comb begin
        other_line = (acc_line != cur_line);
        word_ready = written[acc_word];
        hold       = busy && acc_valid && (other_line || !word_ready);
    end
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl #(
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    parameter int LINE_AW    = 12,
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line,
    input  logic [OFF_W-1:0]   miss_word,
    input  logic               wrap_mode,
    output logic               mem_req,
    output logic [LINE_AW-1:0] mem_line,
    output logic [OFF_W-1:0]   mem_first,
    input  logic               mem_beat_valid,
    input  logic [WORD_W-1:0]  mem_beat_data,
    output logic               line_we,
    output logic [LINE_AW-1:0] line_wline,
    output logic [OFF_W-1:0]   line_widx,
    output logic [WORD_W-1:0]  line_wdata,
    output logic               line_valid_set,
    output logic               stall,
    output logic               busy,
    input  logic               acc_valid,
    input  logic [LINE_AW-1:0] acc_line,
    input  logic [OFF_W-1:0]   acc_word,
    output logic               acc_hold
);
    import rfl_pkg::*;

    rf_state_t state_q, state_d;

    logic                  accept;
    logic                  filling;
    logic                  beat;
    logic [LINE_AW-1:0]    cur_line;
    logic [OFF_W-1:0]      first;
    logic [OFF_W-1:0]      widx;
    logic [LINE_WORDS-1:0] written;
    logic                  req_hit;
    logic                  last_beat;

    assign accept  = (state_q == RF_IDLE) && miss_valid;
    assign filling = (state_q == RF_WAIT_REQ) || (state_q == RF_BACKFILL);
    assign beat    = filling && mem_beat_valid;

    rfl_track #(
        .LINE_WORDS (LINE_WORDS),
        .LINE_AW    (LINE_AW),
        .OFF_W      (OFF_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_line (miss_line),
        .start_word (miss_word),
        .start_wrap (wrap_mode),
        .beat       (beat),
        .cur_line   (cur_line),
        .first      (first),
        .widx       (widx),
        .written    (written),
        .req_hit    (req_hit),
        .last_beat  (last_beat)
    );

    rfl_guard #(
        .LINE_WORDS (LINE_WORDS),
        .LINE_AW    (LINE_AW),
        .OFF_W      (OFF_W)
    ) u_guard (
        .busy      (busy),
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_word  (acc_word),
        .cur_line  (cur_line),
        .written   (written),
        .hold      (acc_hold)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RF_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_IDLE:     if (miss_valid) state_d = RF_ISSUE;
            RF_ISSUE:    state_d = RF_WAIT_REQ;
            RF_WAIT_REQ: begin
                if (last_beat)    state_d = RF_COMMIT;
                else if (req_hit) state_d = RF_BACKFILL;
            end
            RF_BACKFILL: if (last_beat) state_d = RF_COMMIT;
            RF_COMMIT:   state_d = RF_IDLE;
            default:     state_d = RF_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req        = 1'b0;
        stall          = 1'b0;
        busy           = 1'b1;
        line_valid_set = 1'b0;
        unique case (state_q)
            RF_IDLE:     busy = 1'b0;
            RF_ISSUE:    begin mem_req = 1'b1; stall = 1'b1; end
            RF_WAIT_REQ: stall = 1'b1;
            RF_BACKFILL: ;
            RF_COMMIT:   line_valid_set = 1'b1;
            default:     busy = 1'b0;
        endcase
        mem_line   = cur_line;
        mem_first  = first;
        line_we    = beat;
        line_wline = cur_line;
        line_widx  = widx;
        line_wdata = mem_beat_data;
    end
endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
    parameter int LINE_WORDS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic mem_req,
    input logic line_we,
    input logic line_valid_set,
    input logic stall,
    input logic busy,
    input logic acc_valid,
    input logic acc_hold
);
    localparam int CW = $clog2(LINE_WORDS) + 1;
    logic [CW-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        wr_cnt <= '0;
        else if (mem_req)  wr_cnt <= '0;
        else if (line_we)  wr_cnt <= wr_cnt + 1'b1;
    end

    assert_issue_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> mem_req);
    assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !$past(busy));
    assert_write_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> (busy && !mem_req));
    assert_stall_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);
    assert_release_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(line_we));
    assert_valid_after_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_set |-> (wr_cnt == CW'(LINE_WORDS)));
    assert_idle_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_set |=> !busy);
    assert_hold_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hold |-> (busy && acc_valid));
endmodule

bind line_refill_ctrl rfl_checker #(.LINE_WORDS(LINE_WORDS)) u_rfl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .mem_req        (mem_req),
    .line_we        (line_we),
    .line_valid_set (line_valid_set),
    .stall          (stall),
    .busy           (busy),
    .acc_valid      (acc_valid),
    .acc_hold       (acc_hold)
);

// File: tb/tb_line_refill_ctrl.sv
`timescale 1ns/1ps
module tb_line_refill_ctrl;
    localparam int LW = 4;
    localparam int WW = 32;
    localparam int AW = 12;
    localparam int OW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_line = '0;
    logic [OW-1:0] miss_word = '0;
    logic          wrap_mode = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_line;
    logic [OW-1:0] mem_first;
    logic          mem_beat_valid = 1'b0;
    logic [WW-1:0] mem_beat_data = '0;
    logic          line_we;
    logic [AW-1:0] line_wline;
    logic [OW-1:0] line_widx;
    logic [WW-1:0] line_wdata;
    logic          line_valid_set;
    logic          stall;
    logic          busy;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_line = '0;
    logic [OW-1:0] acc_word = '0;
    logic          acc_hold;

    always #5 clk = ~clk;

    line_refill_ctrl #(.LINE_WORDS(LW), .WORD_W(WW), .LINE_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .wrap_mode(wrap_mode), .mem_req(mem_req),
        .mem_line(mem_line), .mem_first(mem_first), .mem_beat_valid(mem_beat_valid),
        .mem_beat_data(mem_beat_data), .line_we(line_we), .line_wline(line_wline),
        .line_widx(line_widx), .line_wdata(line_wdata), .line_valid_set(line_valid_set),
        .stall(stall), .busy(busy), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_word(acc_word), .acc_hold(acc_hold)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pat(input logic [AW-1:0] ln, input logic [OW-1:0] ix);
        return (32'(ln) << 8) ^ (32'(ix) * 32'h01010101) ^ 32'h5A000000;
    endfunction

    // monitor / memory model state
    bit            mem_act = 1'b0;
    int            tick = 0;
    int            beat_k = 0;
    logic [OW-1:0] m_first = '0;
    logic [AW-1:0] m_line = '0;
    int            cyc = 0;
    int            req_cnt, wr_n, stall_cyc, busy_cyc, vcnt, v_wr, data_bad, line_bad;
    int            first_seen, line_seen, stall_after;
    int            order [4];
    bit            req_prev;
    bit  [LW-1:0]  wmask;
    bit            hz_en = 1'b0;
    logic [AW-1:0] fill_line = '0;
    logic [OW-1:0] cur_req = '0;

    initial begin
        forever begin
            @(negedge clk);
            mem_beat_valid = 1'b0;
            if (mem_act) begin
                tick++;
                if (tick == 11 * (beat_k + 1)) begin
                    mem_beat_valid = 1'b1;
                    mem_beat_data  = pat(m_line, m_first + OW'(beat_k));
                    beat_k++;
                    if (beat_k == LW) mem_act = 1'b0;
                end
            end
            if (hz_en) begin
                acc_valid = 1'b1;
                acc_word  = OW'(cyc % 4);
                acc_line  = (cyc % 5 == 0) ? (fill_line ^ 12'h001) : fill_line;
            end else begin
                acc_valid = 1'b0;
            end
            #1;
            if (mem_req) begin
                mem_act = 1'b1; tick = 0; beat_k = 0;
                m_first = mem_first; m_line = mem_line;
                req_cnt++; first_seen = int'(mem_first); line_seen = int'(mem_line);
            end
            if (hz_en) begin
                bit exp_h;
                exp_h = busy && ((acc_line != fill_line) || !wmask[acc_word]);
                check(acc_hold == exp_h, "R9 access hold", int'(acc_hold), int'(exp_h));
            end
            if (req_prev) begin stall_after = int'(stall); req_prev = 1'b0; end
            if (line_we) begin
                if (wr_n < 4) order[wr_n] = int'(line_widx);
                if (line_wdata != pat(fill_line, line_widx)) data_bad++;
                if (line_wline != fill_line) line_bad++;
                wmask[line_widx] = 1'b1;
                wr_n++;
                if (line_widx == cur_req) req_prev = 1'b1;
            end
            if (stall) stall_cyc++;
            if (busy)  busy_cyc++;
            if (line_valid_set) begin vcnt++; v_wr = wr_n; end
            cyc++;
        end
    end

    task automatic run_fill(input logic [AW-1:0] ln, input logic [OW-1:0] rq,
                            input bit wrap, input bit inject, input bit hz);
        int p;
        int t;
        bit ord_ok;
        req_cnt = 0; wr_n = 0; stall_cyc = 0; busy_cyc = 0; vcnt = 0; v_wr = 0;
        data_bad = 0; line_bad = 0; first_seen = -1; line_seen = -1; stall_after = -1;
        req_prev = 1'b0; wmask = '0;
        fill_line = ln; cur_req = rq;
        p = wrap ? 0 : int'(rq);
        @(negedge clk);
        miss_valid = 1'b1; miss_line = ln; miss_word = rq; wrap_mode = wrap;
        hz_en = hz;
        @(negedge clk);
        miss_valid = 1'b0;
        if (inject) begin
            repeat (18) @(negedge clk);
            miss_valid = 1'b1; miss_line = ln ^ 12'hFFF; miss_word = rq + 1'b1; wrap_mode = !wrap;
            @(negedge clk);
            miss_valid = 1'b0;
        end
        t = 0;
        do begin
            @(negedge clk); #2; t++;
        end while (busy && t < 200);
        hz_en = 1'b0;
        @(negedge clk); #2;
        ord_ok = (wr_n == 4);
        for (int k = 0; k < 4; k++)
            if (order[k] != ((wrap ? int'(rq) : 0) + k) % 4) ord_ok = 1'b0;
        check(req_cnt == 1, inject ? "R8 single block read" : "R1 single block read", req_cnt, 1);
        check(first_seen == (wrap ? int'(rq) : 0), "R1 first offset", first_seen, wrap ? int'(rq) : 0);
        check(line_seen == int'(ln), "R1 line address", line_seen, int'(ln));
        check(ord_ok, wrap ? "R3 wrap order" : "R2 sequential order", order[0], wrap ? int'(rq) : 0);
        check(wr_n == 4 && data_bad == 0, "R4 write count and data", wr_n, 4);
        check(line_bad == 0, inject ? "R8 line unchanged" : "R4 line address", line_bad, 0);
        check(stall_cyc == 12 + 11 * p, "R5 stall length", stall_cyc, 12 + 11 * p);
        check(stall_after == 0, "R5 release after requested write", stall_after, 0);
        check(vcnt == 1 && v_wr == 4, "R6 valid pulse", vcnt * 10 + v_wr, 14);
        check(busy_cyc == 46, "R7 busy length", busy_cyc, 46);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!busy && !stall && !mem_req && !line_we && !line_valid_set, "R10 reset outputs",
              int'({busy, stall, mem_req, line_we, line_valid_set}), 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(!busy && !stall && !mem_req, "R10 idle after reset",
              int'({busy, stall, mem_req}), 0);
        for (int w = 0; w < 2; w++)
            for (int r = 0; r < 4; r++)
                run_fill(12'h100 + AW'(w * 16 + r), OW'(r), w[0], 1'b0, 1'b0);
        run_fill(12'hABC, 2'd2, 1'b0, 1'b1, 1'b0);
        run_fill(12'h3C5, 2'd1, 1'b1, 1'b1, 1'b0);
        run_fill(12'h777, 2'd2, 1'b1, 1'b0, 1'b1);
        run_fill(12'h0F0, 2'd1, 1'b0, 1'b0, 1'b1);
        run_fill(12'hFFF, 2'd3, 1'b0, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule